// File: doc/BRIEF.md
# Register-Mapped SPI Host Controller

This block is an SPI bus host controlled through a small register file of 32-bit words. Software picks one of eight chip-select lines by number and asserts it with a separate enable bit. It sets the clock mode, the bit orders and the word width in a configuration register. It then writes a word to the transmit register, which starts one full-duplex exchange. While the word is in flight the interface reports busy. When the word completes, a cause register reads nonzero. Software reads the received word, clears the cause register and moves on to the next word.

The serial clock comes from an internal divider driven by a configuration field. The point at which MISO is captured can be pushed one system clock later through a timing field, which helps at high serial rates. Register reads are combinational from the address; writes take effect at the clock edge.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the following hold: every chip-select line is high, the cause register (offset 0x10) reads 0, the timing register (offset 0x18) reads 0x40 (sample field at bits 7:6 equal to 1), the serial clock is low, and busy (bit 31 of the control register at offset 0x00) is 0.
- R2: Control register bits 4:2 name a chip select from 0 to 7, and control bit 0 asserts it. The chip-select outputs are active low. Only the named line goes low, and only while bit 0 is set.
- R3: A write to the transmit register (offset 0x08) starts one word exchange. When the exchange completes, the cause register reads 1 and the receive register (offset 0x0C) holds the word captured from MISO.
- R4: The serial clock idles at the level of configuration bit 11 (offset 0x04). With configuration bit 12 clear, MISO is captured on the leading clock edge and MOSI changes on the trailing edge. With bit 12 set, MOSI changes on the leading edge and MISO is captured on the trailing edge.
- R5: Configuration bit 13 sends the transmit word least significant bit first. Configuration bit 14 places the first received bit at the least significant position. The two bits act independently. When a bit is clear, that direction is MSB first.
- R6: Configuration bit 5 selects 16-bit words, sending transmit bits 15:0. When bit 5 is clear, the word is 8 bits: only transmit bits 7:0 are sent, and receive bits 15:8 read as zero.
- R7: Any write to the cause register clears it to 0.
- R8: The sample field in timing bits 7:6 resets to 1 and captures MISO at the clock edge. Value 2 captures MISO one system clock after that edge, and the received data stays correct.
- R9: Writes to the transmit register while a word is in flight are ignored. The word in progress completes unchanged, and busy reads 1 while the word is in flight.
- R10: Each serial clock half period lasts (configuration bits 4:0) + 1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| spi_cs_n | output | 8 | Chip selects, active low |

## Verification
A wrong edge count or phase state shows within one word. Either the serial clock does not come back to its idle level, or a bit lands in the wrong place in the word captured from MISO or in the word the target captures from MOSI. A restart caused by an ignored write shows as an edge counter that runs backwards. It also gives a corrupted result for the first word. A bad chip-select decode shows as soon as the control register is written, as a low line other than the one named, or more than one low line.

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int DIV_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [7:0]  spi_cs_n
);
  localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_TX = 5'h08,
                         A_RX = 5'h0C, A_CAUSE = 5'h10, A_TIME = 5'h18;

  logic             cs_assert;
  logic [2:0]       cs_sel;
  logic [14:0]      cfg_q;
  logic [1:0]       tsamp;
  logic             busy, done, phase, pend;
  logic [5:0]       ecnt;
  logic [DIV_W-1:0] tmr;
  logic [15:0]      tx_sr, rx_sr, din_q;

  wire [DIV_W-1:0] div    = cfg_q[DIV_W-1:0];
  wire             wide   = cfg_q[5];
  wire             cpol   = cfg_q[11];
  wire             cpha   = cfg_q[12];
  wire             tx_lsb = cfg_q[13];
  wire             rx_lsb = cfg_q[14];
  wire [5:0]       last   = wide ? 6'd32 : 6'd16;
  wire             start  = reg_we && reg_addr == A_TX && !busy;
  wire             tick   = busy && tmr == div;
  wire             lead   = !ecnt[0];
  wire             edge_now   = tick && ecnt != last;
  wire             sample_now = edge_now && (cpha ? !lead : lead);
  wire             shift_now  = edge_now && (cpha ? (lead && ecnt != 6'd0)
                                                  : (!lead && ecnt != last - 6'd1));
  wire             finish = tick && ecnt == last && !pend;
  wire             unused_ok = ^{reg_wdata[31:15], reg_wdata[10:6]};

  function automatic logic [15:0] rx_next(input logic [15:0] r, input logic b,
                                          input logic lsb, input logic w);
    if (lsb) rx_next = w ? {b, r[15:1]} : {8'h00, b, r[7:1]};
    else     rx_next = w ? {r[14:0], b} : {8'h00, r[6:0], b};
  endfunction

  assign spi_sclk = cpol ^ phase;
  assign spi_mosi = tx_lsb ? tx_sr[0] : (wide ? tx_sr[15] : tx_sr[7]);
  assign spi_cs_n = cs_assert ? ~(8'b1 << cs_sel) : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_assert <= 1'b0;
      cs_sel    <= 3'd0;
      cfg_q     <= '0;
      tsamp     <= 2'd1;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: begin cs_assert <= reg_wdata[0]; cs_sel <= reg_wdata[4:2]; end
        A_CFG:  cfg_q <= reg_wdata[14:0] & 15'h783F;
        A_TIME: tsamp <= reg_wdata[7:6];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      phase <= 1'b0;
      pend  <= 1'b0;
      ecnt  <= '0;
      tmr   <= '0;
      tx_sr <= '0;
      rx_sr <= '0;
      din_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_CAUSE) done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        ecnt  <= '0;
        tmr   <= '0;
        phase <= 1'b0;
        pend  <= 1'b0;
        rx_sr <= '0;
        tx_sr <= wide ? reg_wdata[15:0] : {8'h00, reg_wdata[7:0]};
      end else if (busy) begin
        tmr <= tick ? '0 : tmr + 1'b1;
        if (pend) begin
          rx_sr <= rx_next(rx_sr, spi_miso, rx_lsb, wide);
          pend  <= 1'b0;
        end
        if (edge_now) begin
          phase <= ~phase;
          ecnt  <= ecnt + 6'd1;
        end
        if (sample_now) begin
          if (tsamp == 2'd2) pend <= 1'b1;
          else rx_sr <= rx_next(rx_sr, spi_miso, rx_lsb, wide);
        end
        if (shift_now) tx_sr <= tx_lsb ? {1'b0, tx_sr[15:1]} : {tx_sr[14:0], 1'b0};
        if (finish) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          din_q <= rx_sr;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {busy, 26'd0, cs_sel, 1'b0, cs_assert};
      A_CFG:   reg_rdata = {17'd0, cfg_q};
      A_RX:    reg_rdata = {16'd0, din_q};
      A_CAUSE: reg_rdata = {31'd0, done};
      A_TIME:  reg_rdata = {24'd0, tsamp, 6'd0};
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

module spi_host_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  spi_cs_n,
  input logic        spi_sclk,
  input logic        cs_assert,
  input logic        busy,
  input logic        done,
  input logic        cpol,
  input logic        wide,
  input logic [5:0]  ecnt,
  input logic [15:0] din_q
);
  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1);
  // R2
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_assert |-> spi_cs_n == 8'hFF);
  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_sclk == cpol);
  // R3
  done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ecnt >= $past(ecnt));
  // R6
  narrow_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !wide) |-> din_q[15:8] == 8'h00);
endmodule

bind spi_host_regs spi_host_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .cs_assert(cs_assert), .busy(busy), .done(done), .cpol(cpol),
  .wide(wide), .ecnt(ecnt), .din_q(din_q)
);

// File: tb/spi_host_regs_tb_top.sv
module spi_host_regs_tb_top;
  logic clk = 0, rst_n = 0, we = 0, miso = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic sclk, mosi;
  logic [7:0] cs_n;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  spi_host_regs dut_i (.clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_cs_n(cs_n));

  // target model
  bit sl_on = 0, b_cpol = 0, b_cpha = 0;
  int nb = 8, si = 0;
  logic [15:0] sw = 0, cap = 0;
  always @(sclk) if (sl_on) begin
    if ((sclk != b_cpol) != b_cpha) cap = {cap[14:0], mosi};
    else if (si < nb) begin miso = sw[nb-1-si]; si++; end
  end

  // scoreboard
  logic [31:0] exp_q[$];
  logic [15:0] expc_q[$];
  logic [31:0] act_din;
  logic [15:0] act_cap;
  string cur_req;
  event xfer_done;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  initial forever begin
    logic [31:0] e; logic [15:0] ec;
    @(xfer_done);
    e = exp_q.pop_front(); ec = expc_q.pop_front();
    chk(act_din == e, {cur_req, " R3 received word"}, act_din, e);
    chk(act_cap == ec, {cur_req, " R5 transmitted word"}, {16'd0, act_cap}, {16'd0, ec});
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 0; #1 d = rdata;
  endtask

  function automatic logic [15:0] rev(input logic [15:0] w, input int n);
    logic [15:0] r = 0;
    for (int i = 0; i < n; i++) r[i] = w[n-1-i];
    return r;
  endfunction

  task automatic run(input string req, input logic [4:0] div, input bit w16, input bit cp,
                     input bit ch, input bit tl, input bit rl, input logic [15:0] tx,
                     input logic [15:0] s, input bit extra);
    logic [31:0] v; logic [15:0] m; int guard;
    sl_on = 0;
    wr(5'h04, {17'd0, rl, tl, ch, cp, 5'd0, w16, div});
    nb = w16 ? 16 : 8;
    m = w16 ? 16'hFFFF : 16'h00FF;
    exp_q.push_back({16'd0, rl ? rev(s & m, nb) : (s & m)});
    expc_q.push_back(tl ? rev(tx & m, nb) : (tx & m));
    b_cpol = cp; b_cpha = ch; sw = s & m; cap = 0;
    if (!ch) begin miso = sw[nb-1]; si = 1; end else si = 0;
    sl_on = 1;
    wr(5'h10, 0);
    wr(5'h08, {16'hA5A5, tx});
    if (extra) begin
      wr(5'h08, {16'd0, ~tx});
      rd(5'h00, v);
      chk(v[31] == 1'b1, "R9 busy during word", {31'd0, v[31]}, 1);
    end
    guard = 0;
    do begin rd(5'h10, v); guard++; end while (v == 0 && guard < 2000);
    chk(v == 1, {req, " R3 cause after word"}, v, 1);
    rd(5'h0C, v);
    act_din = v; act_cap = cap & m; cur_req = req;
    sl_on = 0;
    -> xfer_done;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v; int n; logic old;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(cs_n == 8'hFF, "R1 cs after reset", {24'd0, cs_n}, 32'hFF);
    chk(sclk == 0, "R1 sclk after reset", {31'd0, sclk}, 0);
    rd(5'h10, v); chk(v == 0, "R1 cause after reset", v, 0);
    rd(5'h18, v); chk(v == 32'h40, "R1 timing after reset", v, 32'h40);
    rd(5'h00, v); chk(v == 0, "R1 control after reset", v, 0);

    wr(5'h00, (5 << 2) | 1);
    @(negedge clk); chk(cs_n == 8'hDF, "R2 cs 5 asserted", {24'd0, cs_n}, 32'hDF);
    wr(5'h00, (5 << 2));
    @(negedge clk); chk(cs_n == 8'hFF, "R2 cs released", {24'd0, cs_n}, 32'hFF);
    wr(5'h00, (0 << 2) | 1);
    @(negedge clk); chk(cs_n == 8'hFE, "R2 cs 0 asserted", {24'd0, cs_n}, 32'hFE);

    run("mode0 8b msb", 5'd1, 0, 0, 0, 0, 0, 16'h00B4, 16'h0039, 0);
    run("mode3 16b txlsb", 5'd2, 1, 1, 1, 1, 0, 16'hC3A1, 16'h5E72, 0);
    run("mode1 8b rxlsb R6", 5'd0, 0, 0, 1, 0, 1, 16'hFF6D, 16'h00C8, 0);
    run("mode2 16b both lsb", 5'd3, 1, 1, 0, 1, 1, 16'h1234, 16'h8E01, 0);

    chk(sclk == 1, "R4 sclk idles at cpol=1", {31'd0, sclk}, 1);
    wr(5'h10, 0);
    rd(5'h10, v); chk(v == 0, "R7 cause cleared", v, 0);

    wr(5'h18, 32'h80);
    rd(5'h18, v); chk(v == 32'h80, "R8 timing readback", v, 32'h80);
    run("R8 delayed sample mode3", 5'd2, 1, 1, 1, 0, 0, 16'h9AC5, 16'h3C6F, 0);
    run("R8 delayed sample mode0", 5'd0, 0, 0, 0, 0, 0, 16'h0057, 16'h00A9, 0);
    wr(5'h18, 32'h40);

    run("R9 ignored write", 5'd3, 0, 0, 0, 0, 0, 16'h0081, 16'h0066, 1);

    // R10 half period
    wr(5'h04, 32'd3);
    wr(5'h08, 32'h55);
    old = sclk;
    while (sclk == old) begin @(posedge clk); #1; end
    old = sclk; n = 0;
    do begin @(posedge clk); n++; #1; end while (sclk == old && n < 50);
    chk(n == 4, "R10 half period clocks", n, 4);
    repeat (200) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule